// File: doc/BRIEF.md
# Pipelined 32x32 Multiplier with Condition Flags

This unit forms the full 64-bit product of two 32-bit operands, treating them either as unsigned numbers or as two's complement numbers according to a mode input. Alongside the product it produces a five-bit condition nibble: extend (X), negative (N), zero (Z), overflow (V) and carry (C). The caller presents one operation per cycle with a valid strobe. Each result comes out a fixed three cycles later with its own valid strobe, as a high word and a low word.

Internally each operand is first reduced to its magnitude. The two magnitudes are split into 16-bit halves and four 16x16 unsigned partial products are formed. The partial products are then summed at their bit offsets, and the sum is negated when exactly one signed operand was negative. The zero flag comes only from an explicit test for a zero operand. The extend flag passes through from the caller's incoming value. Overflow and carry are always cleared.

Top module: `wide_mult_cc`

## Requirements
- R1: With `in_signed` = 0, `{out_hi, out_lo}` equals the product of the two operands, each zero-extended to 64 bits.
- R2: With `in_signed` = 1, `{out_hi, out_lo}` equals the 64-bit two's complement product of the two operands, each taken as a signed 32-bit value. This includes 0x80000000 times 0x80000000, which gives 0x4000000000000000, and -1 times -1, which gives 1.
- R3: When either operand is zero, the product is 0. The flag nibble then has Z (bit 2) set, N (bit 3), V (bit 1) and C (bit 0) clear, and X (bit 4) equal to the incoming X.
- R4: For non-zero operands, N (bit 3 of `out_flags`) equals bit 63 of the product, in both modes.
- R5: X (bit 4 of `out_flags`) equals the `in_xflag` value that was presented with the same operation.
- R6: V (bit 1) and C (bit 0) of `out_flags` are 0 on every valid result.
- R7: Z (bit 2) is 0 on every result whose operands were both non-zero.
- R8: `out_vld` rises exactly three rising clock edges after the edge that samples `in_vld` = 1. Results keep issue order, one per cycle under back-to-back input, and `out_vld` stays low otherwise.
- R9: While `rst_n` is low, `out_vld`, `out_hi`, `out_lo` and `out_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operation strobe, one operation per cycle |
| in_signed | input | 1 | 1 selects two's complement operands, 0 selects unsigned |
| in_mplier | input | 32 | Multiplier operand |
| in_mcand | input | 32 | Multiplicand operand |
| in_xflag | input | 1 | Incoming extend flag, returned unchanged in the result |
| out_vld | output | 1 | Result strobe |
| out_hi | output | 32 | Product bits 63..32 |
| out_lo | output | 32 | Product bits 31..0 |
| out_flags | output | 5 | Condition nibble {X, N, Z, V, C}, X in bit 4 |

## Verification
The assertions take for granted that `in_vld` and `in_xflag` have known values at every sampling edge after reset, and that `in_vld` is held low during reset. Their reference history of strobes and extend flags starts from reset on that basis. They check timing and flag relations only. Product values are left to the scoreboard, which computes a 64-bit reference from the operands. The stimulus changes inputs only on falling edges and drives `in_vld` low for the whole reset interval. It mixes back-to-back operations with idle gaps, so the latency and idle-low properties see both kinds of traffic.

// File: rtl/mulcc_pkg.sv
package mulcc_pkg;
    // Layout of the condition nibble: {X, N, Z, V, C}
    localparam int FLAG_W = 5;
    localparam int FL_X   = 4;
    localparam int FL_N   = 3;
    localparam int FL_Z   = 2;
    localparam int FL_V   = 1;
    localparam int FL_C   = 0;
    // Number of partial products for a two-half split
    localparam int PP_N   = 4;
endpackage

// File: rtl/mulcc_condition.sv
// Reduces both operands to magnitudes and derives the result sign
// and the zero-operand shortcut.
module mulcc_condition #(
    parameter int OP_W = 32
) (
    input  logic            signed_mode,
    input  logic [OP_W-1:0] opa,
    input  logic [OP_W-1:0] opb,
    output logic [OP_W-1:0] mag_a,
    output logic [OP_W-1:0] mag_b,
    output logic            res_neg,
    output logic            any_zero
);
    localparam logic [OP_W-1:0] ONE = OP_W'(1);

    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg    = signed_mode & opa[OP_W-1];
        b_neg    = signed_mode & opb[OP_W-1];
        mag_a    = a_neg ? (~opa + ONE) : opa;
        mag_b    = b_neg ? (~opb + ONE) : opb;
        res_neg  = a_neg ^ b_neg;
        any_zero = (opa == '0) | (opb == '0);
    end
endmodule

// File: rtl/mulcc_partials.sv
// Four half-width unsigned products.
// Index bit 0 selects the upper half of A, index bit 1 the upper half of B.
module mulcc_partials #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]                        mag_a,
    input  logic [OP_W-1:0]                        mag_b,
    output logic [mulcc_pkg::PP_N-1:0][OP_W-1:0]   pp
);
    localparam int HALF = OP_W / 2;

    for (genvar i = 0; i < mulcc_pkg::PP_N; i++) begin : g_pp
        localparam int A_OFF = (i % 2) * HALF;
        localparam int B_OFF = (i / 2) * HALF;
        logic [HALF-1:0] a_part;
        logic [HALF-1:0] b_part;
        assign a_part = mag_a[A_OFF +: HALF];
        assign b_part = mag_b[B_OFF +: HALF];
        assign pp[i]  = {{HALF{1'b0}}, a_part} * {{HALF{1'b0}}, b_part};
    end
endmodule

// File: rtl/mulcc_combine.sv
// Aligns and sums the partial products, restores the sign and forms the flags.
module mulcc_combine
    import mulcc_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic [PP_N-1:0][OP_W-1:0] pp,
    input  logic                      res_neg,
    input  logic                      any_zero,
    input  logic                      xin,
    output logic [OP_W-1:0]           prod_hi,
    output logic [OP_W-1:0]           prod_lo,
    output logic [FLAG_W-1:0]         flags
);
    localparam int HALF = OP_W / 2;
    localparam logic [OP_W-1:0] ONE = OP_W'(1);

    logic [OP_W-1:0] mid;
    logic [OP_W-1:0] mag_hi;
    logic [OP_W-1:0] mag_lo;
    logic [OP_W-1:0] neg_lo;
    logic            lo_carry;

    always_comb begin
        // middle column: upper half of lo*lo plus lower halves of both cross terms
        mid    = (pp[0] >> HALF)
               + {{HALF{1'b0}}, pp[1][HALF-1:0]}
               + {{HALF{1'b0}}, pp[2][HALF-1:0]};
        mag_lo = {mid[HALF-1:0], pp[0][HALF-1:0]};
        mag_hi = pp[3] + (pp[1] >> HALF) + (pp[2] >> HALF) + (mid >> HALF);

        // two's complement over both words, carry from low into high
        {lo_carry, neg_lo} = {1'b0, ~mag_lo} + {1'b0, ONE};

        flags        = '0;
        flags[FL_X]  = xin;
        if (any_zero) begin
            prod_hi     = '0;
            prod_lo     = '0;
            flags[FL_Z] = 1'b1;
        end else begin
            prod_lo     = res_neg ? neg_lo : mag_lo;
            prod_hi     = res_neg ? (~mag_hi + {{(OP_W-1){1'b0}}, lo_carry}) : mag_hi;
            flags[FL_N] = prod_hi[OP_W-1];
        end
    end
endmodule

// File: rtl/wide_mult_cc.sv
// Three-stage multiplier: operand conditioning | partial products | sum, sign, flags
module wide_mult_cc
    import mulcc_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_signed,
    input  logic [OP_W-1:0]   in_mplier,
    input  logic [OP_W-1:0]   in_mcand,
    input  logic              in_xflag,
    output logic              out_vld,
    output logic [OP_W-1:0]   out_hi,
    output logic [OP_W-1:0]   out_lo,
    output logic [FLAG_W-1:0] out_flags
);
    typedef struct packed {
        logic            vld;
        logic            x;
        logic            neg;
        logic            zero;
        logic [OP_W-1:0] ma;
        logic [OP_W-1:0] mb;
    } cond_t;

    typedef struct packed {
        logic                      vld;
        logic                      x;
        logic                      neg;
        logic                      zero;
        logic [PP_N-1:0][OP_W-1:0] pp;
    } part_t;

    typedef struct packed {
        logic              vld;
        logic [OP_W-1:0]   hi;
        logic [OP_W-1:0]   lo;
        logic [FLAG_W-1:0] fl;
    } res_t;

    typedef struct packed {
        cond_t c;
        part_t p;
        res_t  r;
    } pipe_t;

    pipe_t st_d;
    pipe_t st_q;

    logic [OP_W-1:0]           mag_a;
    logic [OP_W-1:0]           mag_b;
    logic                      res_neg;
    logic                      any_zero;
    logic [PP_N-1:0][OP_W-1:0] pp;
    logic [OP_W-1:0]           sum_hi;
    logic [OP_W-1:0]           sum_lo;
    logic [FLAG_W-1:0]         sum_fl;

    mulcc_condition #(.OP_W(OP_W)) u_cond (
        .signed_mode (in_signed),
        .opa         (in_mplier),
        .opb         (in_mcand),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .res_neg     (res_neg),
        .any_zero    (any_zero)
    );

    mulcc_partials #(.OP_W(OP_W)) u_parts (
        .mag_a (st_q.c.ma),
        .mag_b (st_q.c.mb),
        .pp    (pp)
    );

    mulcc_combine #(.OP_W(OP_W)) u_comb (
        .pp       (st_q.p.pp),
        .res_neg  (st_q.p.neg),
        .any_zero (st_q.p.zero),
        .xin      (st_q.p.x),
        .prod_hi  (sum_hi),
        .prod_lo  (sum_lo),
        .flags    (sum_fl)
    );

    always_comb begin
        st_d = st_q;

        st_d.c.vld  = in_vld;
        st_d.c.x    = in_xflag;
        st_d.c.neg  = res_neg;
        st_d.c.zero = any_zero;
        st_d.c.ma   = mag_a;
        st_d.c.mb   = mag_b;

        st_d.p.vld  = st_q.c.vld;
        st_d.p.x    = st_q.c.x;
        st_d.p.neg  = st_q.c.neg;
        st_d.p.zero = st_q.c.zero;
        st_d.p.pp   = pp;

        st_d.r.vld  = st_q.p.vld;
        if (st_q.p.vld) begin
            st_d.r.hi = sum_hi;
            st_d.r.lo = sum_lo;
            st_d.r.fl = sum_fl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld   = st_q.r.vld;
    assign out_hi    = st_q.r.hi;
    assign out_lo    = st_q.r.lo;
    assign out_flags = st_q.r.fl;
endmodule

// File: rtl/mulcc_checker.sv
module mulcc_checker
    import mulcc_pkg::*;
#(
    parameter int OP_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic              in_xflag,
    input logic              out_vld,
    input logic [OP_W-1:0]   out_hi,
    input logic [OP_W-1:0]   out_lo,
    input logic [FLAG_W-1:0] out_flags
);
    localparam int DEPTH = 3;

    logic [DEPTH-1:0] vld_hist;
    logic [DEPTH-1:0] x_hist;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_hist <= '0;
            x_hist   <= '0;
        end else begin
            vld_hist <= {vld_hist[DEPTH-2:0], in_vld};
            x_hist   <= {x_hist[DEPTH-2:0], in_xflag};
        end
    end

    // R8
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == vld_hist[DEPTH-1]);

    // R5
    x_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_flags[FL_X] == x_hist[DEPTH-1]);

    // R6
    vc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_flags[FL_V] == 1'b0 && out_flags[FL_C] == 1'b0));

    // R4
    n_from_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_flags[FL_Z]) |-> out_flags[FL_N] == out_hi[OP_W-1]);

    // R3
    zero_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_flags[FL_Z]) |-> ({out_hi, out_lo} == '0 && !out_flags[FL_N]));

    // R7
    z_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && {out_hi, out_lo} != '0) |-> !out_flags[FL_Z]);
endmodule

bind wide_mult_cc mulcc_checker #(.OP_W(OP_W)) u_mulcc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_xflag  (in_xflag),
    .out_vld   (out_vld),
    .out_hi    (out_hi),
    .out_lo    (out_lo),
    .out_flags (out_flags)
);

// File: tb/wide_mult_cc_test.sv
module wide_mult_cc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic        in_signed = 1'b0;
    logic [31:0] in_mplier = '0;
    logic [31:0] in_mcand = '0;
    logic        in_xflag = 1'b0;
    logic        out_vld;
    logic [31:0] out_hi;
    logic [31:0] out_lo;
    logic [4:0]  out_flags;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;

    typedef struct packed {
        logic [63:0] prod;
        logic [4:0]  flags;
        logic        sgn;
        logic        zop;
        logic [31:0] due;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    wide_mult_cc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_signed (in_signed),
        .in_mplier (in_mplier),
        .in_mcand  (in_mcand),
        .in_xflag  (in_xflag),
        .out_vld   (out_vld),
        .out_hi    (out_hi),
        .out_lo    (out_lo),
        .out_flags (out_flags)
    );

    task automatic push_op(input logic [31:0] a, input logic [31:0] b,
                           input logic s, input logic x);
        exp_t e;
        longint sa;
        longint sb_v;
        @(negedge clk);
        in_vld    = 1'b1;
        in_signed = s;
        in_mplier = a;
        in_mcand  = b;
        in_xflag  = x;
        if (s) begin
            sa     = longint'($signed(a));
            sb_v   = longint'($signed(b));
            e.prod = 64'(sa * sb_v);
        end else begin
            e.prod = {32'b0, a} * {32'b0, b};
        end
        e.zop   = (a == 0) || (b == 0);
        e.sgn   = s;
        e.flags = e.zop ? {x, 1'b0, 1'b1, 2'b00} : {x, e.prod[63], 1'b0, 2'b00};
        e.due   = cyc + 3;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_mplier = $urandom;
            in_mcand  = $urandom;
        end
    endtask

    // monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        cyc++;
        if (rst_n) begin
            if (out_vld) begin
                n_chk++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL R8: out_vld=1 actual, expected 0 (nothing pending)");
                end else begin
                    e = sb.pop_front();
                    if (e.due != cyc) begin
                        n_bad++;
                        $display("FAIL R8: result at cycle %0d, expected %0d", cyc, e.due);
                    end
                    n_chk++;
                    if ({out_hi, out_lo} != e.prod) begin
                        n_bad++;
                        if (e.sgn) $display("FAIL R2: product %h expected %h", {out_hi, out_lo}, e.prod);
                        else       $display("FAIL R1: product %h expected %h", {out_hi, out_lo}, e.prod);
                    end
                    n_chk++;
                    if (out_flags != e.flags) begin
                        n_bad++;
                        if (e.zop) $display("FAIL R3: flags %b expected %b", out_flags, e.flags);
                        else       $display("FAIL R4 R5 R6 R7: flags %b expected %b", out_flags, e.flags);
                    end
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                n_chk++;
                n_bad++;
                e = sb.pop_front();
                $display("FAIL R8: out_vld=0 actual, expected 1 at cycle %0d", e.due);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        n_chk++;
        if (out_vld !== 1'b0 || out_hi !== '0 || out_lo !== '0 || out_flags !== '0) begin
            n_bad++;
            $display("FAIL R9: vld=%b hi=%h lo=%h fl=%b expected all 0",
                     out_vld, out_hi, out_lo, out_flags);
        end
        rst_n = 1'b1;
        idle(2);

        // corner operands, back to back (R2, R1, R3, R4)
        push_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
        push_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
        push_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
        push_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
        push_op(32'h0000_0000, 32'h1234_5678, 1'b0, 1'b1);
        push_op(32'h8765_4321, 32'h0000_0000, 1'b1, 1'b0);
        push_op(32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1);
        push_op(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0);
        push_op(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b1);
        push_op(32'h0000_FFFF, 32'hFFFF_0000, 1'b0, 1'b0);
        push_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0);
        push_op(32'h0001_0000, 32'h0001_0000, 1'b0, 1'b1);
        idle(5);

        // random traffic with gaps (R1 R2 R4 R5 R6 R7 R8)
        for (int i = 0; i < 400; i++) begin
            push_op($urandom, $urandom, 1'($urandom), 1'($urandom));
            if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
        end
        // small and sign-boundary operands
        for (int i = 0; i < 100; i++) begin
            push_op(32'($urandom % 5) - 32'd2, 32'h8000_0000 ^ 32'($urandom % 3),
                    1'($urandom), 1'($urandom));
        end
        idle(10);

        done = 1'b1;
        if (sb.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8: %0d results outstanding, expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule